// File: doc/BRIEF.md
# Register Hazard Stall Controller

This block sits between the decode stage and the later stages of a five-stage in-order pipeline that has no operand forwarding. Each cycle it compares the two source register IDs of the instruction in decode with both destination IDs of every instruction in the execute, memory and write-back stages. On any match the instruction in decode must wait, because its operands are not yet in the register file.

While a hazard is present, three things happen together. The fetch side is told to hold its instruction. The decode register keeps its contents. The execute register loads a nop-shaped bubble. That bubble then drains through memory and write-back like any other instruction. A small pipeline of parameterizable registers, each with load, hold and bubble modes, is included so that the effect of the controls can be seen at the write-back end. The register file, the ALU and branch recovery are outside this block.

The reserved ID 8 stands for "no register". It never produces a match, on either side of the compare. A bubble carries ID 8 in every ID field, so a bubble can never cause a further stall.

Top module: `hz_stall_ctrl`

## Requirements
- R1: A hazard is raised when the decode-stage src_a or src_b equals dst_e or dst_m of the instruction held in the execute, memory or write-back stage register.
- R2: ID 8 never matches. A source of 8, or a destination of 8, causes no hazard even when the two values are equal.
- R3: While a hazard is present, f_stall_o is 1 so that fetch presents the same instruction again, and the decode register keeps its contents across the edge.
- R4: While a hazard is present, the execute register loads a bubble: icode 1 with dst_e and dst_m both 8. The bubble moves one stage per cycle and reaches the write-back outputs three edges later.
- R5: f_stall_o, d_stall_o and e_bubble_o are combinational functions of the current register contents. They are always equal to each other and change in the same cycle the hazard appears or clears.
- R6: A consumer placed directly after its producer gets 3 bubbles. With one nop between them it gets 2, with two nops 1, and with three nops none.
- R7: After reset, every stage register holds the bubble pattern and all three controls are 0. With no hazard, an instruction leaves decode on the edge after it is accepted and appears at write-back three edges later, in program order.
- R8: Instruction fields are icode (4 bits) and the IDs src_a, src_b, dst_e and dst_m (4 bits each). IDs 0 to 7 are real registers. The nop icode is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| f_icode_i | input | 4 | icode of the fetched instruction |
| f_src_a_i | input | 4 | First source ID of the fetched instruction |
| f_src_b_i | input | 4 | Second source ID of the fetched instruction |
| f_dst_e_i | input | 4 | ALU result destination ID |
| f_dst_m_i | input | 4 | Memory result destination ID |
| f_stall_o | output | 1 | Hold the fetched instruction |
| d_stall_o | output | 1 | Decode register in hold mode |
| e_bubble_o | output | 1 | Execute register in bubble mode |
| w_icode_o | output | 4 | icode in the write-back stage |
| w_dst_e_o | output | 4 | dst_e in the write-back stage |
| w_dst_m_o | output | 4 | dst_m in the write-back stage |

## Verification
The bench builds the block with its defaults: three late stages, 4-bit IDs and the none ID 8. With these values a single program can show every bubble count from three down to zero. It places a consumer zero to three nops after its producer, with the hazard reached through each pairing of source and destination field. The program also includes a write to register 0 and a sequence in which equal ID-8 fields must stay silent. A reference timing model in the bench predicts the hazard state of every cycle and the full write-back stream, including each bubble, and the monitor checks both against the outputs.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned ICODE_W = 4;
  localparam logic [ID_W-1:0]    ID_NONE   = ID_W'(8);
  localparam logic [ICODE_W-1:0] ICODE_NOP = ICODE_W'(1);

  typedef struct packed {
    logic [ICODE_W-1:0] icode;
    logic [ID_W-1:0]    src_a;
    logic [ID_W-1:0]    src_b;
    logic [ID_W-1:0]    dst_e;
    logic [ID_W-1:0]    dst_m;
  } instr_t;

  // payload past decode: sources are no longer needed
  typedef struct packed {
    logic [ICODE_W-1:0] icode;
    logic [ID_W-1:0]    dst_e;
    logic [ID_W-1:0]    dst_m;
  } late_t;

  localparam instr_t INSTR_NOP = '{icode: ICODE_NOP, src_a: ID_NONE, src_b: ID_NONE,
                                   dst_e: ID_NONE, dst_m: ID_NONE};
  localparam late_t  LATE_NOP  = '{icode: ICODE_NOP, dst_e: ID_NONE, dst_m: ID_NONE};

  function automatic logic id_match(logic [ID_W-1:0] src, logic [ID_W-1:0] dst);
    return (src != ID_NONE) && (dst != ID_NONE) && (src == dst);
  endfunction
endpackage

// File: rtl/hz_pipe_reg.sv
module hz_pipe_reg #(
  parameter int unsigned   W          = 12,
  parameter logic [W-1:0]  BUBBLE_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stall_i,
  input  logic         bubble_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= BUBBLE_VAL;
    else if (bubble_i)  q_o <= BUBBLE_VAL;
    else if (!stall_i)  q_o <= d_i;
  end

  assert_mode_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_i && bubble_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !bubble_i) |=> (q_o == $past(q_o)));

  assert_bubble_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> (q_o == BUBBLE_VAL));
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
#(
  parameter int unsigned NUM_LATE = 3
) (
  input  logic [ID_W-1:0]                src_a_i,
  input  logic [ID_W-1:0]                src_b_i,
  input  logic [NUM_LATE-1:0][ID_W-1:0]  dst_e_i,
  input  logic [NUM_LATE-1:0][ID_W-1:0]  dst_m_i,
  output logic                           hazard_o
);
  logic [NUM_LATE-1:0] hit;

  for (genvar s = 0; s < NUM_LATE; s++) begin : g_stage
    assign hit[s] = id_match(src_a_i, dst_e_i[s]) | id_match(src_a_i, dst_m_i[s]) |
                    id_match(src_b_i, dst_e_i[s]) | id_match(src_b_i, dst_m_i[s]);
  end

  assign hazard_o = |hit;
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned NUM_LATE = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ICODE_W-1:0] f_icode_i,
  input  logic [ID_W-1:0]    f_src_a_i,
  input  logic [ID_W-1:0]    f_src_b_i,
  input  logic [ID_W-1:0]    f_dst_e_i,
  input  logic [ID_W-1:0]    f_dst_m_i,
  output logic               f_stall_o,
  output logic               d_stall_o,
  output logic               e_bubble_o,
  output logic [ICODE_W-1:0] w_icode_o,
  output logic [ID_W-1:0]    w_dst_e_o,
  output logic [ID_W-1:0]    w_dst_m_o
);
  localparam int unsigned IW = $bits(instr_t);
  localparam int unsigned LW = $bits(late_t);

  instr_t f_in, d_q;
  late_t  stg_d   [NUM_LATE];
  late_t  stg_q   [NUM_LATE];
  logic [NUM_LATE-1:0][ID_W-1:0] late_dst_e, late_dst_m;
  logic hazard;

  assign f_in = '{icode: f_icode_i, src_a: f_src_a_i, src_b: f_src_b_i,
                  dst_e: f_dst_e_i, dst_m: f_dst_m_i};

  hz_pipe_reg #(.W(IW), .BUBBLE_VAL(INSTR_NOP)) u_dreg (
    .clk_i, .rst_ni, .stall_i(hazard), .bubble_i(1'b0), .d_i(f_in), .q_o(d_q)
  );

  for (genvar s = 0; s < NUM_LATE; s++) begin : g_late
    if (s == 0) begin : g_exec
      assign stg_d[s] = '{icode: d_q.icode, dst_e: d_q.dst_e, dst_m: d_q.dst_m};
      hz_pipe_reg #(.W(LW), .BUBBLE_VAL(LATE_NOP)) u_reg (
        .clk_i, .rst_ni, .stall_i(1'b0), .bubble_i(hazard), .d_i(stg_d[s]), .q_o(stg_q[s])
      );
    end else begin : g_pass
      assign stg_d[s] = stg_q[s-1];
      hz_pipe_reg #(.W(LW), .BUBBLE_VAL(LATE_NOP)) u_reg (
        .clk_i, .rst_ni, .stall_i(1'b0), .bubble_i(1'b0), .d_i(stg_d[s]), .q_o(stg_q[s])
      );
    end
    assign late_dst_e[s] = stg_q[s].dst_e;
    assign late_dst_m[s] = stg_q[s].dst_m;
  end

  hz_detect #(.NUM_LATE(NUM_LATE)) u_detect (
    .src_a_i(d_q.src_a), .src_b_i(d_q.src_b),
    .dst_e_i(late_dst_e), .dst_m_i(late_dst_m), .hazard_o(hazard)
  );

  assign f_stall_o  = hazard;
  assign d_stall_o  = hazard;
  assign e_bubble_o = hazard;

  assign w_icode_o = stg_q[NUM_LATE-1].icode;
  assign w_dst_e_o = stg_q[NUM_LATE-1].dst_e;
  assign w_dst_m_o = stg_q[NUM_LATE-1].dst_m;

  assert_ctrl_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_stall_o |-> (f_stall_o && e_bubble_o));

  assert_none_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_q.src_a == ID_NONE && d_q.src_b == ID_NONE) |-> !d_stall_o);

  assert_bubble_flow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_bubble_o |=> (stg_q[0].icode == ICODE_NOP && stg_q[0].dst_e == ID_NONE &&
                    stg_q[0].dst_m == ID_NONE));
endmodule

// File: tb/sim_hz_stall_ctrl.sv
module sim_hz_stall_ctrl;
  import hz_pkg::*;
  localparam int NL = 3;
  localparam int N  = 22;
  localparam logic [3:0] X = 4'd8;

  logic clk = 0, rst_ni = 0;
  logic [3:0] f_icode, f_sa, f_sb, f_de, f_dm, w_icode, w_de, w_dm;
  logic f_stall, d_stall, e_bubble;
  always #5 clk = ~clk;

  hz_stall_ctrl #(.NUM_LATE(NL)) u0 (
    .clk_i(clk), .rst_ni, .f_icode_i(f_icode), .f_src_a_i(f_sa), .f_src_b_i(f_sb),
    .f_dst_e_i(f_de), .f_dst_m_i(f_dm), .f_stall_o(f_stall), .d_stall_o(d_stall),
    .e_bubble_o(e_bubble), .w_icode_o(w_icode), .w_dst_e_o(w_de), .w_dst_m_o(w_dm)
  );

  int checks = 0, fails = 0, exp_total = 0, obs_total = 0, maxc = 0;
  instr_t prog [N];
  bit     exp_stall [512];
  late_t  sb_q [$];

  function automatic logic m(logic [3:0] s, logic [3:0] d);
    return s != X && d != X && s == d;
  endfunction

  function automatic instr_t mk(int ic, int a, int b, int e, int mm);
    return '{icode: 4'(ic), src_a: 4'(a), src_b: 4'(b), dst_e: 4'(e), dst_m: 4'(mm)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // driver side: reference timing model fills the scoreboard
  task automatic build_expect();
    int last [N];
    int prev_w = 0;
    instr_t nop = mk(1, 8, 8, 8, 8);
    prog[0]  = mk(2, 8, 8, 2, 8);  prog[1]  = mk(2, 2, 8, 3, 8);   // R6 adjacent: 3
    prog[2]  = mk(2, 8, 8, 4, 8);  prog[3]  = nop;
    prog[4]  = mk(2, 4, 8, 8, 8);                                // R6 one nop: 2
    prog[5]  = mk(3, 8, 8, 8, 5);  prog[6]  = nop; prog[7] = nop;
    prog[8]  = mk(2, 8, 5, 8, 8);                                // R6 two nops, dst_m: 1
    prog[9]  = mk(2, 8, 8, 6, 8);  prog[10] = nop; prog[11] = nop; prog[12] = nop;
    prog[13] = mk(2, 6, 8, 8, 8);                                // R6 three nops: 0
    prog[14] = mk(2, 8, 8, 8, 8);  prog[15] = mk(2, 8, 8, 7, 8);  // R2 none vs none
    prog[16] = mk(2, 0, 7, 8, 1);                                // R1 src_b vs dst_e
    prog[17] = mk(2, 1, 1, 0, 8);                                // R1 via dst_m
    for (int i = 18; i < N; i++) prog[i] = nop;
    for (int i = 0; i < N; i++) begin
      int enter = (i == 0) ? 1 : last[i-1] + 1;
      int l = enter, w;
      for (int j = 0; j < i; j++)
        if (m(prog[i].src_a, prog[j].dst_e) || m(prog[i].src_a, prog[j].dst_m) ||
            m(prog[i].src_b, prog[j].dst_e) || m(prog[i].src_b, prog[j].dst_m))
          if (last[j] + NL + 1 > l) l = last[j] + NL + 1;
      last[i] = l;
      for (int c = enter; c < l; c++) begin exp_stall[c] = 1; exp_total++; end
      w = l + NL;
      for (int c = prev_w + 1; c < w; c++) sb_q.push_back(LATE_NOP);
      sb_q.push_back('{icode: prog[i].icode, dst_e: prog[i].dst_e, dst_m: prog[i].dst_m});
      prev_w = w;
    end
    maxc = prev_w + 2;
  endtask

  task automatic drive();
    int k = 0;
    for (int c = 0; c <= maxc; c++) begin
      instr_t cur = (k < N) ? prog[k] : INSTR_NOP;
      {f_icode, f_sa, f_sb, f_de, f_dm} = cur;
      if (!f_stall && k < N) k++;
      @(negedge clk);
    end
  endtask

  task automatic monitor();
    for (int c = 0; c <= maxc; c++) begin
      chk(d_stall == exp_stall[c], "R1 R2 R3 stall", d_stall, exp_stall[c]);
      chk(f_stall == d_stall && e_bubble == d_stall, "R5 controls", {f_stall, e_bubble}, {2{d_stall}});
      if (d_stall) obs_total++;
      if (c >= 1 && sb_q.size() > 0) begin
        late_t e = sb_q.pop_front();
        late_t a = '{icode: w_icode, dst_e: w_de, dst_m: w_dm};
        chk(a == e, (e == LATE_NOP) ? "R4 bubble at write-back" : "R7 R8 retire order", a, e);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    bit timeout = 0;
    {f_icode, f_sa, f_sb, f_de, f_dm} = INSTR_NOP;
    build_expect();
    repeat (3) @(negedge clk);
    chk(!f_stall && !d_stall && !e_bubble, "R7 reset controls", {f_stall, d_stall, e_bubble}, 0);
    chk(w_icode == 4'd1 && w_de == X && w_dm == X, "R7 reset stage", {w_icode, w_de, w_dm}, 12'h188);
    rst_ni = 1;
    fork
      begin fork drive(); monitor(); join end
      begin repeat (20000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) chk(0, "watchdog", 0, 1);
    chk(obs_total == exp_total, "R6 total bubbles", obs_total, exp_total);
    chk(sb_q.size() == 0, "R4 R7 stream drained", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule